// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a block of words between a memory port and a device port so the processor does not have to. Software loads a start address, a word count and a control word through a small register write port. Setting the enable bit arms the channel. From then on the engine asks for the system bus whenever the device requests service. It drives memory and device strobes only while the bus is granted. It advances the address and counts the words down by itself.

Three ownership policies decide how long the bus is kept. The first holds it for the whole block. The second gives it back after every word. The third keeps asking but moves words only while the processor reports its bus as idle. When the count reaches zero the engine drops its request and clears its enable. If the interrupt enable is set, it raises an interrupt that stays high until software writes the control register.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: `mem_addr_o` shows the current address register. It increments by one in the cycle after each word's write strobe, including the last word.
- R2: The word count decrements once per word moved. A transfer moves exactly the programmed number of words and then stops.
- R3: Register select 0 loads the address, 1 loads the count and 2 loads control. Control bit 0 is enable, bit 1 is direction (0 memory to device, 1 device to memory) and bit 2 is interrupt enable. Bits 4:3 are the mode: 00 hold for the block, 01 release per word, 10 idle-only.
- R4: Each word is a read strobe on the source port that is latched into a data buffer, then a write strobe on the target port carrying that buffered word. Both strobes are never high in the same cycle.
- R5: While the channel is enabled and `dev_req_i` is high, `bus_req_o` rises. No memory or device strobe is driven unless `bus_grant_i` and `dev_req_i` are high. After reset, the request, interrupt and all strobes are low.
- R6: In mode 00, `bus_req_o` stays high without a gap from the first word to the last.
- R7: In mode 01, `bus_req_o` falls in the cycle after every word's write strobe, so an N-word block shows N separate request pulses.
- R8: In mode 10, no strobe is driven while `cpu_idle_i` is low, even with the bus granted.
- R9: On completion `bus_req_o` falls. If interrupt enable was set, `irq_o` rises and holds until a control register write. With interrupt enable clear, `irq_o` stays low.
- R10: Register writes of any select are ignored while a transfer is active.
- R11: Enabling with a count of zero completes at once, with no bus request and no strobes, and raises the interrupt if enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 address, 1 count, 2 control) |
| reg_wdata_i | input | REG_W | Register write data |
| dev_req_i | input | 1 | Device service request |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| cpu_idle_i | input | 1 | Processor not using the bus |
| bus_req_o | output | 1 | Bus request |
| mem_addr_o | output | AW | Memory word address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid in the strobe cycle |
| dev_rd_o | output | 1 | Device read strobe |
| dev_wr_o | output | 1 | Device write strobe |
| dev_wdata_o | output | DW | Device write data |
| dev_rdata_i | input | DW | Device read data, valid in the strobe cycle |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench counts request rises and falls across a block. A design that releases the bus between words in hold mode, or keeps it in per-word mode, shows the wrong pulse count. It withholds the grant, the device request and the idle signal one at a time while a channel is armed. A design that strobes without them moves words early. It rewrites address, count and control in the middle of a stalled transfer. A design that honours those writes ends at the wrong address, moves the wrong number of words or never interrupts. A zero count and a disabled interrupt are also run: the first would either hang or start a bus cycle, and the second would raise a spurious interrupt.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_STEAL = 2'd1,
    MODE_QUIET = 2'd2,
    MODE_RSVD  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ARB,
    SEQ_READ,
    SEQ_WRITE
  } seq_state_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic       irq_en;
    logic       dir;     // 1: device to memory
    logic       enable;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_xfer_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             word_done_i,
  input  logic             finish_i,
  output logic [AW-1:0]    addr_o,
  output logic [CW-1:0]    count_o,
  output ctrl_t            ctrl_o,
  output logic             irq_o
);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  ctrl_t         ctrl_q;
  logic          irq_q;
  logic          wr_ok;
  logic          unused_wdata;

  assign wr_ok        = we_i && !ctrl_q.enable;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ok) begin
        unique case (sel_i)
          SEL_ADDR:  addr_q  <= wdata_i[AW-1:0];
          SEL_COUNT: count_q <= wdata_i[CW-1:0];
          SEL_CTRL: begin
            ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
            irq_q  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (word_done_i) begin
        addr_q  <= addr_q + 1'b1;
        count_q <= count_q - 1'b1;
      end
      if (finish_i) begin
        ctrl_q.enable <= 1'b0;
        if (ctrl_q.irq_en) irq_q <= 1'b1;
      end
    end
  end

  assign addr_o  = addr_q;
  assign count_o = count_q;
  assign ctrl_o  = ctrl_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       count_zero_i,
  input  logic       last_i,
  input  xfer_mode_e mode_i,
  input  logic       dev_req_i,
  input  logic       bus_grant_i,
  input  logic       cpu_idle_i,
  output logic       bus_req_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic       word_done_o,
  output logic       finish_o
);

  seq_state_e state_q, state_d;
  logic       go;

  // bus usable this cycle
  assign go = bus_grant_i && dev_req_i && (mode_i != MODE_QUIET || cpu_idle_i);

  always_comb begin
    state_d     = state_q;
    rd_o        = 1'b0;
    wr_o        = 1'b0;
    word_done_o = 1'b0;
    finish_o    = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (active_i && count_zero_i) finish_o = 1'b1;
        else if (active_i && dev_req_i) state_d = SEQ_ARB;
      end
      SEQ_ARB: if (go) state_d = SEQ_READ;
      SEQ_READ: begin
        if (go) begin
          rd_o    = 1'b1;
          state_d = SEQ_WRITE;
        end
      end
      SEQ_WRITE: begin
        if (go) begin
          wr_o        = 1'b1;
          word_done_o = 1'b1;
          if (last_i) begin
            finish_o = 1'b1;
            state_d  = SEQ_IDLE;
          end else if (mode_i == MODE_STEAL) begin
            state_d = SEQ_IDLE;
          end else begin
            state_d = SEQ_READ;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign bus_req_o = (state_q != SEQ_IDLE);

endmodule

// File: rtl/dma_xfer_path.sv
module dma_xfer_path #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] dev_rdata_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          dev_rd_o,
  output logic          dev_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] dev_wdata_o
);

  logic [DW-1:0] buf_q;

  assign mem_rd_o = rd_i && !dir_i;
  assign dev_rd_o = rd_i &&  dir_i;
  assign dev_wr_o = wr_i && !dir_i;
  assign mem_wr_o = wr_i &&  dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   buf_q <= '0;
    else if (rd_i) buf_q <= dir_i ? dev_rdata_i : mem_rdata_i;
  end

  assign mem_wdata_o = buf_q;
  assign dev_wdata_o = buf_q;

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             dev_req_i,
  input  logic             bus_grant_i,
  input  logic             cpu_idle_i,
  output logic             bus_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             dev_rd_o,
  output logic             dev_wr_o,
  output logic [DW-1:0]    dev_wdata_o,
  input  logic [DW-1:0]    dev_rdata_i,
  output logic             irq_o
);

  localparam logic [CW-1:0] COUNT_ONE = CW'(1);

  logic [CW-1:0] count;
  ctrl_t         ctrl;
  logic          word_done, finish, rd, wr;

  dma_xfer_regs #(.AW(AW), .CW(CW), .REG_W(REG_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .word_done_i (word_done),
    .finish_i    (finish),
    .addr_o      (mem_addr_o),
    .count_o     (count),
    .ctrl_o      (ctrl),
    .irq_o       (irq_o)
  );

  dma_xfer_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (ctrl.enable),
    .count_zero_i (count == '0),
    .last_i       (count == COUNT_ONE),
    .mode_i       (ctrl.mode),
    .dev_req_i    (dev_req_i),
    .bus_grant_i  (bus_grant_i),
    .cpu_idle_i   (cpu_idle_i),
    .bus_req_o    (bus_req_o),
    .rd_o         (rd),
    .wr_o         (wr),
    .word_done_o  (word_done),
    .finish_o     (finish)
  );

  dma_xfer_path #(.DW(DW)) u_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_i       (ctrl.dir),
    .rd_i        (rd),
    .wr_i        (wr),
    .mem_rdata_i (mem_rdata_i),
    .dev_rdata_i (dev_rdata_i),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .dev_rd_o    (dev_rd_o),
    .dev_wr_o    (dev_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .dev_wdata_o (dev_wdata_o)
  );

endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_grant_i,
  input logic          dev_req_i,
  input logic          cpu_idle_i,
  input logic [1:0]    mode_i,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          dev_rd_o,
  input logic          dev_wr_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          irq_o,
  input logic          reg_we_i,
  input logic [1:0]    reg_sel_i
);

  logic any_strobe, any_write;
  assign any_strobe = mem_rd_o | mem_wr_o | dev_rd_o | dev_wr_o;
  assign any_write  = mem_wr_o | dev_wr_o;

  assert_strobe_granted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |-> (bus_grant_i && bus_req_o && dev_req_i));

  assert_one_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, dev_rd_o, dev_wr_o}));

  assert_quiet_needs_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && any_strobe) |-> cpu_idle_i);

  assert_steal_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && any_write) |=> !bus_req_o);

  assert_addr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_write |=> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_we_i && reg_sel_i == 2'd2)) |=> irq_o);

endmodule

bind dma_xfer_ctrl dma_xfer_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_o   (bus_req_o),
  .bus_grant_i (bus_grant_i),
  .dev_req_i   (dev_req_i),
  .cpu_idle_i  (cpu_idle_i),
  .mode_i      (ctrl.mode),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .dev_rd_o    (dev_rd_o),
  .dev_wr_o    (dev_wr_o),
  .mem_addr_o  (mem_addr_o),
  .irq_o       (irq_o),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i)
);

// File: tb/dma_xfer_ctrl_bench.sv
module dma_xfer_ctrl_bench;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_sel_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic          dev_req_i = 1'b0;
  logic          bus_grant_i = 1'b0;
  logic          cpu_idle_i = 1'b0;
  logic          bus_req_o, mem_rd_o, mem_wr_o, dev_rd_o, dev_wr_o, irq_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i, dev_wdata_o, dev_rdata_i;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [DW-1:0] mem [16];
  logic [DW-1:0] dev_log [16];
  int  n_mem_rd, n_mem_wr, n_dev_rd, n_dev_wr, n_rise, n_fall;
  logic prev_req;
  logic mon_clr = 1'b0;

  always #2 clk_i = ~clk_i;

  dma_xfer_ctrl u_dma_xfer_ctrl (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .dev_req_i, .bus_grant_i, .cpu_idle_i, .bus_req_o,
    .mem_addr_o, .mem_rd_o, .mem_wr_o, .mem_wdata_o, .mem_rdata_i,
    .dev_rd_o, .dev_wr_o, .dev_wdata_o, .dev_rdata_i, .irq_o
  );

  assign mem_rdata_i = mem[mem_addr_o[3:0]];
  assign dev_rdata_i = 32'hA000 + DW'(n_dev_rd);

  always @(posedge clk_i) begin
    if (mon_clr) begin
      n_mem_rd <= 0; n_mem_wr <= 0; n_dev_rd <= 0; n_dev_wr <= 0;
      n_rise <= 0; n_fall <= 0; prev_req <= 1'b0;
    end else begin
      if (mem_rd_o) n_mem_rd <= n_mem_rd + 1;
      if (mem_wr_o) n_mem_wr <= n_mem_wr + 1;
      if (dev_rd_o) n_dev_rd <= n_dev_rd + 1;
      if (dev_wr_o) begin
        dev_log[n_dev_wr[3:0]] <= dev_wdata_o;
        n_dev_wr <= n_dev_wr + 1;
      end
      prev_req <= bus_req_o;
      if (bus_req_o && !prev_req) n_rise <= n_rise + 1;
      if (!bus_req_o && prev_req) n_fall <= n_fall + 1;
    end
    if (mem_wr_o) mem[mem_addr_o[3:0]] <= mem_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = val;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic clear_mon();
    @(negedge clk_i); mon_clr = 1'b1;
    @(negedge clk_i); mon_clr = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic start(input int addr, input int cnt, input logic [4:0] ctl);
    clear_mon();
    wr_reg(2'd0, 32'(addr));
    wr_reg(2'd1, 32'(cnt));
    wr_reg(2'd2, {27'd0, ctl});
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(bus_req_o == 1'b0, "R5 reset bus_req", 32'(bus_req_o), 0);
    chk(irq_o == 1'b0, "R9 reset irq", 32'(irq_o), 0);
    chk({mem_rd_o, mem_wr_o, dev_rd_o, dev_wr_o} == 4'b0, "R5 reset strobes",
        32'({mem_rd_o, mem_wr_o, dev_rd_o, dev_wr_o}), 0);
  endtask

  // control: 0x05 = enable | irq_en, hold mode, memory to device
  task automatic t_hold();
    dev_req_i = 1; bus_grant_i = 1; cpu_idle_i = 0;
    start(3, 4, 5'h05);
    run(30);
    chk(n_dev_wr == 4, "R2 hold word count", 32'(n_dev_wr), 4);
    for (int i = 0; i < 4; i++)
      chk(dev_log[i] == 32'h1003 + 32'(i), "R4 hold data order", dev_log[i], 32'h1003 + 32'(i));
    chk(n_rise == 1 && n_fall == 1, "R6 hold single request pulse", 32'(n_rise), 1);
    chk(mem_addr_o == 16'd7, "R1 final address", 32'(mem_addr_o), 7);
    chk(bus_req_o == 0, "R9 bus released", 32'(bus_req_o), 0);
    chk(irq_o == 1, "R9 irq raised", 32'(irq_o), 1);
  endtask

  task automatic t_irq_clear();
    run(10);
    chk(irq_o == 1, "R9 irq held", 32'(irq_o), 1);
    wr_reg(2'd2, 32'h0);
    @(negedge clk_i);
    chk(irq_o == 0, "R9 irq cleared by control write", 32'(irq_o), 0);
  endtask

  // 0x0F = enable | dir | irq_en | mode 01
  task automatic t_steal();
    start(8, 3, 5'h0F);
    run(30);
    chk(n_mem_wr == 3, "R2 steal word count", 32'(n_mem_wr), 3);
    chk(n_rise == 3 && n_fall == 3, "R7 steal request pulses", 32'(n_rise), 3);
    for (int i = 0; i < 3; i++)
      chk(mem[8 + i] == 32'hA000 + 32'(i), "R4 device to memory data", mem[8 + i], 32'hA000 + 32'(i));
    chk(irq_o == 1, "R9 steal irq", 32'(irq_o), 1);
    wr_reg(2'd2, 32'h0);
  endtask

  // 0x15 = enable | irq_en | mode 10
  task automatic t_quiet();
    cpu_idle_i = 0;
    start(0, 2, 5'h15);
    run(20);
    chk(n_mem_rd == 0 && n_dev_wr == 0, "R8 no strobe while cpu busy", 32'(n_mem_rd), 0);
    chk(bus_req_o == 1, "R5 request pending in quiet mode", 32'(bus_req_o), 1);
    @(negedge clk_i); cpu_idle_i = 1;
    run(20);
    chk(n_dev_wr == 2, "R8 quiet words moved", 32'(n_dev_wr), 2);
    chk(dev_log[1] == 32'h1001, "R8 quiet data", dev_log[1], 32'h1001);
    chk(irq_o == 1, "R9 quiet irq", 32'(irq_o), 1);
    cpu_idle_i = 0;
    wr_reg(2'd2, 32'h0);
  endtask

  task automatic t_ignore_writes();
    bus_grant_i = 0;
    start(12, 2, 5'h05);
    run(10);
    chk(n_mem_rd == 0, "R5 no strobe without grant", 32'(n_mem_rd), 0);
    chk(bus_req_o == 1, "R5 request raised", 32'(bus_req_o), 1);
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h9);
    wr_reg(2'd2, 32'h0);
    @(negedge clk_i); bus_grant_i = 1;
    run(20);
    chk(n_dev_wr == 2, "R10 count write ignored", 32'(n_dev_wr), 2);
    chk(dev_log[0] == 32'h100C, "R10 address write ignored", dev_log[0], 32'h100C);
    chk(mem_addr_o == 16'd14, "R10 final address", 32'(mem_addr_o), 14);
    chk(irq_o == 1, "R10 control write ignored", 32'(irq_o), 1);
    wr_reg(2'd2, 32'h0);
  endtask

  task automatic t_no_irq();
    start(4, 1, 5'h01);
    run(15);
    chk(n_dev_wr == 1 && dev_log[0] == 32'h1004, "R2 single word", dev_log[0], 32'h1004);
    chk(irq_o == 0, "R9 irq disabled", 32'(irq_o), 0);
    chk(bus_req_o == 0, "R9 released without irq", 32'(bus_req_o), 0);
  endtask

  task automatic t_zero();
    start(5, 0, 5'h05);
    run(10);
    chk(irq_o == 1, "R11 zero count irq", 32'(irq_o), 1);
    chk(n_rise == 0 && n_mem_rd == 0, "R11 zero count no bus", 32'(n_rise), 0);
    wr_reg(2'd2, 32'h0);
  endtask

  task automatic t_dev_req();
    dev_req_i = 0;
    start(6, 1, 5'h0D);
    run(10);
    chk(bus_req_o == 0 && n_rise == 0, "R5 no request without device", 32'(n_rise), 0);
    @(negedge clk_i); dev_req_i = 1;
    run(15);
    chk(n_dev_wr == 1 && dev_log[0] == 32'h1006, "R5 device request serviced", dev_log[0], 32'h1006);
    chk(irq_o == 1, "R3 irq_en bit honoured", 32'(irq_o), 1);
    wr_reg(2'd2, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000 + 32'(i);
    mon_clr = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    mon_clr = 1'b0;
    t_reset();
    t_hold();
    t_irq_clear();
    t_steal();
    t_quiet();
    t_ignore_writes();
    t_no_irq();
    t_zero();
    t_dev_req();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule